// File: doc/BRIEF.md
# Pixel Component Unpacker

This block sits between a framebuffer fetch path and a display output stage. It takes one raw pixel word per valid cycle and turns it into an 8-bit red, green and blue triple. A format register states how many of the word's low bytes form a pixel; the remaining bytes are treated as zero. Each colour channel has its own select register. That register gives the position of the field's lowest bit, the field's length, and a fallback colour value.

Each channel isolates its field and left-justifies it into 8 bits. Short fields are padded with zeros below; long fields are cut to their upper 8 bits. The fallback value replaces the extracted value in three cases: when the pixel is flagged as blanking, when it is flagged as an underrun, or when the channel's length is zero. Configuration is written through a plain address/data write strobe. The result appears one clock after the pixel is presented.

Top module: `pxu_unpacker`

## Requirements
- R1: After reset, `out_valid` is 0 and all three colour outputs are 0. All configuration fields reset to 0, so a pixel presented before any write yields 0 on every channel.
- R2: The format register is at address 0. Bits [4:3] hold bytes-per-pixel minus one, so 0 means one byte. Bytes of `pix_word` at byte index greater than or equal to the bytes-per-pixel count read as zero during extraction.
- R3: The select registers are at address 1 (red), 2 (green) and 3 (blue). The fallback value is in bits [23:16], the field length in bits [11:8], and the lowest bit index in bits [4:0]. All other written bits are ignored.
- R4: A channel with length L from 1 to 7 outputs the L bits starting at its lowest bit index. These bits occupy output bits [7:8-L], and the bits below them are zero.
- R5: A channel with length L from 8 to 15 outputs the upper 8 bits of its L-bit field. For L = 8 this is the field unchanged.
- R6: A channel whose length is 0 outputs its fallback value.
- R7: A pixel presented with `pix_blank` high yields the fallback value on all three channels.
- R8: A pixel presented with `pix_underrun` high yields the fallback value on all three channels.
- R9: The outputs for a pixel accepted at a clock edge appear after that edge, with `out_valid` high for that one cycle. After a cycle with `pix_valid` low, `out_valid` is low and the colour outputs keep their previous values.
- R10: A configuration write in the same cycle as a pixel does not affect that pixel. The write applies from the next pixel onward.
- R11: A write to addresses 4 to 7 changes no configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W (3) | Configuration register address |
| cfg_wdata | input | CFG_W (32) | Configuration write data |
| pix_valid | input | 1 | A pixel word is presented this cycle |
| pix_word | input | WORD_W (32) | Raw pixel word, pixel in the low bytes |
| pix_blank | input | 1 | Pixel lies outside the visible area |
| pix_underrun | input | 1 | Pixel data arrived late |
| out_valid | output | 1 | Colour outputs carry a new pixel |
| out_red | output | 8 | Red component |
| out_green | output | 8 | Green component |
| out_blue | output | 8 | Blue component |

## Verification
Directed patterns use typical 16-bit and 24-bit layouts. A pure red word and a pure green word show whether each channel reads its own field and aligns it to the top. A field placed above a one-byte pixel separates correct byte masking from plain shifting. Lengths of 8 and 12 separate truncation from padding. Zero length, blanking and underrun each force the fallback value against a word that would otherwise produce a non-zero colour. A write landing in the same cycle as a pixel, and a write to an unused address, show when configuration takes effect and which addresses it decodes. Long random runs mix all field positions, lengths, byte counts and flags against a bench model of the requirements.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  localparam int COMP_W = 8;
  localparam int LEN_W = 4;
  localparam int LSB_W = 5;
  localparam int NUM_CH = 3;

  // write-data field positions
  localparam int FMT_BPP_LO = 3;
  localparam int SEL_DFLT_LO = 16;
  localparam int SEL_LEN_LO = 8;
  localparam int SEL_LSB_LO = 0;

  // register addresses; channel n select sits at ADDR_SEL0 + n (red, green, blue)
  localparam int ADDR_FMT = 0;
  localparam int ADDR_SEL0 = 1;

  typedef struct packed {
    logic [COMP_W-1:0] dflt;
    logic [LEN_W-1:0] len;
    logic [LSB_W-1:0] lsb;
  } sel_t;
endpackage

// File: rtl/pxu_rst_sync.sv
module pxu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_int_n = stage_q[1];
endmodule

// File: rtl/pxu_cfg_regs.sv
module pxu_cfg_regs
  import pxu_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int CFG_W = 32,
  parameter int BPP_W = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [CFG_W-1:0]              wdata,
  output logic [BPP_W-1:0]              bpp_m1,
  output sel_t [NUM_CH-1:0]             sel
);
  logic [BPP_W-1:0]  fmt_q, fmt_d;
  logic              fmt_en;
  sel_t [NUM_CH-1:0] sel_q, sel_d;
  logic [NUM_CH-1:0] sel_en;
  sel_t              wr_sel;

  always_comb begin
    fmt_en = we && (addr == ADDR_W'(ADDR_FMT));
    fmt_d  = wdata[FMT_BPP_LO +: BPP_W];
    wr_sel.dflt = wdata[SEL_DFLT_LO +: COMP_W];
    wr_sel.len  = wdata[SEL_LEN_LO +: LEN_W];
    wr_sel.lsb  = wdata[SEL_LSB_LO +: LSB_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fmt_q <= '0;
    else if (fmt_en) fmt_q <= fmt_d;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_sel
    always_comb begin
      sel_en[ch] = we && (addr == ADDR_W'(ADDR_SEL0 + ch));
      sel_d[ch]  = wr_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          sel_q[ch] <= '0;
      else if (sel_en[ch]) sel_q[ch] <= sel_d[ch];
    end
  end

  assign bpp_m1 = fmt_q;
  assign sel    = sel_q;
endmodule

// File: rtl/pxu_byte_mask.sv
module pxu_byte_mask #(
  parameter int WORD_W = 32,
  parameter int BPP_W = 2
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [BPP_W-1:0]  bpp_m1,
  output logic [WORD_W-1:0] word_o
);
  localparam int NBYTES = WORD_W / 8;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign word_o[b*8 +: 8] = (b <= int'(bpp_m1)) ? word_i[b*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/pxu_chan_extract.sv
module pxu_chan_extract
  import pxu_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word_i,
  input  sel_t              sel_i,
  input  logic              force_dflt_i,
  output logic [COMP_W-1:0] comp_o
);
  localparam int FLD_W = (1 << LEN_W) - 1;
  localparam int WIDE_W = FLD_W + COMP_W;

  logic [WORD_W-1:0] shifted;
  logic [FLD_W-1:0]  len_mask;
  logic [FLD_W-1:0]  fld;
  logic [WIDE_W-1:0] wide;
  logic [WIDE_W-1:0] aligned;
  int                len_i;

  always_comb begin
    len_i   = int'(sel_i.len);
    shifted = word_i >> sel_i.lsb;
    for (int i = 0; i < FLD_W; i++) len_mask[i] = (i < len_i);
    fld  = shifted[FLD_W-1:0] & len_mask;
    wide = WIDE_W'(fld);
    if (len_i >= COMP_W) aligned = wide >> (len_i - COMP_W);
    else                 aligned = wide << (COMP_W - len_i);
    comp_o = (force_dflt_i || (sel_i.len == '0)) ? sel_i.dflt : aligned[COMP_W-1:0];
  end
endmodule

// File: rtl/pxu_unpacker.sv
module pxu_unpacker
  import pxu_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 3,
  parameter int CFG_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              pix_valid,
  input  logic [WORD_W-1:0] pix_word,
  input  logic              pix_blank,
  input  logic              pix_underrun,
  output logic              out_valid,
  output logic [7:0]        out_red,
  output logic [7:0]        out_green,
  output logic [7:0]        out_blue
);
  localparam int BPP_W = $clog2(WORD_W / 8);

  logic                          rst_int_n;
  logic [BPP_W-1:0]              bpp_m1;
  sel_t [NUM_CH-1:0]             sel_q;
  logic [WORD_W-1:0]             masked;
  logic                          force_dflt;
  logic [NUM_CH-1:0][COMP_W-1:0] comp_c, comp_d, comp_q;
  logic                          valid_d, valid_q;

  pxu_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  pxu_cfg_regs #(.ADDR_W(ADDR_W), .CFG_W(CFG_W), .BPP_W(BPP_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .we     (cfg_we),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .bpp_m1 (bpp_m1),
    .sel    (sel_q)
  );

  pxu_byte_mask #(.WORD_W(WORD_W), .BPP_W(BPP_W)) u_mask (
    .word_i (pix_word),
    .bpp_m1 (bpp_m1),
    .word_o (masked)
  );

  assign force_dflt = pix_blank || pix_underrun;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    pxu_chan_extract #(.WORD_W(WORD_W)) u_ext (
      .word_i       (masked),
      .sel_i        (sel_q[ch]),
      .force_dflt_i (force_dflt),
      .comp_o       (comp_c[ch])
    );
  end

  always_comb begin
    valid_d = pix_valid;
    comp_d  = comp_c;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) valid_q <= 1'b0;
    else            valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)     comp_q <= '0;
    else if (pix_valid) comp_q <= comp_d;
  end

  assign out_valid = valid_q;
  assign out_red   = comp_q[0];
  assign out_green = comp_q[1];
  assign out_blue  = comp_q[2];
endmodule

// File: rtl/pxu_unpacker_chk.sv
module pxu_unpacker_chk
  import pxu_pkg::*;
(
  input logic       clk,
  input logic       rst_int_n,
  input logic       pix_valid,
  input logic       pix_blank,
  input logic       pix_underrun,
  input logic [1:0] bpp_m1,
  input sel_t       red_sel,
  input logic       out_valid,
  input logic [7:0] out_red,
  input logic [7:0] out_green,
  input logic [7:0] out_blue
);
  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    pix_valid |=> out_valid);

  // R9
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !pix_valid |=> !out_valid);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !pix_valid |=> ($stable(out_red) && $stable(out_green) && $stable(out_blue)));

  // R7
  blank_dflt_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pix_valid && pix_blank) |=> (out_red == $past(red_sel.dflt)));

  // R8
  underrun_dflt_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pix_valid && pix_underrun) |=> (out_red == $past(red_sel.dflt)));

  // R6
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pix_valid && (red_sel.len == 4'd0)) |=> (out_red == $past(red_sel.dflt)));

  // R2
  narrow_mask_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pix_valid && !pix_blank && !pix_underrun && (bpp_m1 == 2'd0) &&
     (red_sel.lsb >= 5'd8) && (red_sel.len != 4'd0)) |=> (out_red == 8'h00));
endmodule

bind pxu_unpacker pxu_unpacker_chk u_chk (
  .clk          (clk),
  .rst_int_n    (rst_int_n),
  .pix_valid    (pix_valid),
  .pix_blank    (pix_blank),
  .pix_underrun (pix_underrun),
  .bpp_m1       (bpp_m1),
  .red_sel      (sel_q[0]),
  .out_valid    (out_valid),
  .out_red      (out_red),
  .out_green    (out_green),
  .out_blue     (out_blue)
);

// File: tb/pxu_unpacker_bench.sv
`timescale 1ns/1ps
module pxu_unpacker_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        pix_valid;
  logic [31:0] pix_word;
  logic        pix_blank;
  logic        pix_underrun;
  logic        out_valid;
  logic [7:0]  out_red, out_green, out_blue;

  always #2 clk = ~clk;

  pxu_unpacker u_pxu_unpacker (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pix_valid(pix_valid), .pix_word(pix_word),
    .pix_blank(pix_blank), .pix_underrun(pix_underrun), .out_valid(out_valid),
    .out_red(out_red), .out_green(out_green), .out_blue(out_blue)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // shadow configuration
  logic [1:0] m_bpp;
  logic [7:0] m_dflt [3];
  logic [3:0] m_len [3];
  logic [4:0] m_lsb [3];

  // pending expectation
  bit         have_exp;
  logic       e_valid;
  logic [7:0] e_rgb [3];
  string      e_tag;

  task automatic cmp(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_comp(input logic [31:0] w, input logic [1:0] bm1,
                                          input int ch, input logic bl, input logic un);
    int nbits;
    logic [31:0] m;
    longint f;
    int len;
    if (bl || un || m_len[ch] == 4'd0) return m_dflt[ch];
    nbits = (int'(bm1) + 1) * 8;
    m = (nbits == 32) ? w : (w & ((32'd1 << nbits) - 32'd1));
    len = int'(m_len[ch]);
    f = (longint'(m) >> m_lsb[ch]) & ((64'd1 << len) - 64'd1);
    if (len >= 8) return 8'(f >> (len - 8));
    return 8'(f << (8 - len));
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // one cycle: check previous expectation, model new inputs, drive them
  task automatic step(input logic we, input logic [2:0] addr, input logic [31:0] wd,
                      input logic pv, input logic [31:0] w, input logic bl,
                      input logic un, input string tag);
    string t;
    @(negedge clk);
    if (have_exp) begin
      cmp(e_tag, "valid", {7'd0, out_valid}, {7'd0, e_valid});
      cmp(e_tag, "red",   out_red,   e_rgb[0]);
      cmp(e_tag, "green", out_green, e_rgb[1]);
      cmp(e_tag, "blue",  out_blue,  e_rgb[2]);
    end
    t = tag;
    if (t == "") begin
      if (!pv) t = "R9";
      else if (bl) t = "R7";
      else if (un) t = "R8";
      else if (m_len[0] == 4'd0) t = "R6";
      else if (m_len[0] >= 4'd8) t = "R5";
      else t = "R4";
    end
    e_tag = t;
    e_valid = pv;
    if (pv) for (int c = 0; c < 3; c++) e_rgb[c] = ref_comp(w, m_bpp, c, bl, un);
    have_exp = 1;
    // shadow write after the pixel is modelled (R10)
    if (we) begin
      if (addr == 3'd0) m_bpp = wd[4:3];
      else if (addr <= 3'd3) begin
        m_dflt[addr-1] = wd[23:16];
        m_len[addr-1]  = wd[11:8];
        m_lsb[addr-1]  = wd[4:0];
      end
    end
    cfg_we = we; cfg_addr = addr; cfg_wdata = wd;
    pix_valid = pv; pix_word = w; pix_blank = bl; pix_underrun = un;
  endtask

  task automatic wr(input logic [2:0] addr, input logic [31:0] wd, input string tag);
    step(1'b1, addr, wd, 1'b0, 32'h0, 1'b0, 1'b0, tag);
  endtask

  task automatic px(input logic [31:0] w, input logic bl, input logic un, input string tag);
    step(1'b0, 3'd0, 32'h0, 1'b1, w, bl, un, tag);
  endtask

  function automatic logic [31:0] selw(input logic [7:0] d, input logic [3:0] l, input logic [4:0] s);
    return {8'h00, d, 4'h0, l, 3'b000, s};
  endfunction

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL R9 watchdog expired: actual running expected done");
    summary();
  end

  initial begin
    m_bpp = '0;
    for (int c = 0; c < 3; c++) begin m_dflt[c] = '0; m_len[c] = '0; m_lsb[c] = '0; e_rgb[c] = '0; end
    have_exp = 0; e_valid = 0; e_tag = "R1";
    rst_n = 1'b0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    pix_valid = 0; pix_word = 0; pix_blank = 0; pix_underrun = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    cmp("R1", "valid", {7'd0, out_valid}, 8'd0);
    cmp("R1", "red", out_red, 8'h00);
    cmp("R1", "green", out_green, 8'h00);
    cmp("R1", "blue", out_blue, 8'h00);
    px(32'hFFFF_FFFF, 0, 0, "R1");
    // R3 16-bit 5:6:5 layout
    wr(3'd0, 32'h0000_0008, "R3");
    wr(3'd1, selw(8'h11, 4'd5, 5'd11) | 32'hFF00_E0E0, "R3");
    wr(3'd2, selw(8'h22, 4'd6, 5'd5), "R3");
    wr(3'd3, selw(8'h33, 4'd5, 5'd0), "R3");
    px(32'h0000_F800, 0, 0, "R4");
    px(32'h0000_07E0, 0, 0, "R4");
    px(32'h0000_001F, 0, 0, "R4");
    px(32'hFFFF_0000, 0, 0, "R2");
    // R2 one byte per pixel, field above it
    wr(3'd0, 32'h0000_0000, "R2");
    wr(3'd1, selw(8'h44, 4'd8, 5'd8), "R2");
    px(32'hFFFF_FFFF, 0, 0, "R2");
    // R2 four bytes, top byte
    wr(3'd0, 32'h0000_0018, "R2");
    wr(3'd1, selw(8'h44, 4'd8, 5'd24), "R2");
    px(32'hA5FF_FFFF, 0, 0, "R2");
    // R5 long field truncation
    wr(3'd2, selw(8'h00, 4'd12, 5'd0), "R5");
    px(32'h0000_0ABC, 0, 0, "R5");
    // R6 zero length
    wr(3'd3, selw(8'h5A, 4'd0, 5'd0), "R6");
    px(32'hFFFF_FFFF, 0, 0, "R6");
    // R7 and R8
    wr(3'd1, selw(8'hFF, 4'd8, 5'd0), "R8");
    px(32'h1234_5678, 1, 0, "R7");
    px(32'h1234_5678, 0, 1, "R8");
    // R9 idle holds
    step(0, 0, 0, 0, 32'hDEAD_BEEF, 0, 0, "R9");
    step(0, 0, 0, 0, 32'h0, 1, 1, "R9");
    // R10 write concurrent with pixel
    step(1, 3'd1, selw(8'h00, 4'd4, 5'd4), 1, 32'h0000_00F0, 0, 0, "R10");
    px(32'h0000_00F0, 0, 0, "R10");
    // R11 unused addresses
    for (int a = 4; a < 8; a++) wr(3'(a), 32'hFFFF_FFFF, "R11");
    px(32'h00C3_B2A1, 0, 0, "R11");
    // random mix
    void'($urandom(32'h1F2E_3D4C));
    for (int i = 0; i < 4000; i++) begin
      logic we_r;
      logic [31:0] r;
      r = $urandom;
      we_r = (r[1:0] == 2'b00);
      step(we_r, 3'($urandom), $urandom, (r[4:2] != 3'b000), $urandom,
           (r[8:5] == 4'h0), (r[12:9] == 4'h0), "");
    end
    step(0, 0, 0, 0, 0, 0, 0, "R9");
    summary();
  end
endmodule